// File: doc/BRIEF.md
# Out-of-Order Issue Window

This block sits between instruction decode and the functional units of a pipeline that has no register renaming. It holds a small pool of decoded instructions. Each instruction carries an opcode, a functional-unit class, one destination register and two source registers. Decode offers one instruction per cycle. The window takes it only when a slot is free and the newcomer cannot create a write-after-write or write-after-read conflict with anything the window still tracks. Because of this rule, a destination register name appears at most once among outstanding instructions.

In every cycle the window may send one held instruction to its functional unit. An instruction is eligible when none of its sources is the destination of another outstanding instruction and its target unit is not busy. Program order does not limit this choice. When several instructions are eligible, the oldest by time of entry wins. A dispatched instruction keeps its slot until a writeback with its destination register arrives. That writeback frees the slot and can release instructions that were waiting on the register. Operand values, datapaths and renaming lie outside this block.

Top module: `iw_window`

## Requirements
- R1: After reset the window is empty: `disp_valid` is 0 and `in_ready` is 1 for any offered instruction.
- R2: With all slots occupied (held or dispatched and not yet written back), `in_ready` is 0 and the offered instruction is not taken. Decode keeps it on the inputs and retries.
- R3: `in_ready` is 0 while `in_dst` equals the destination of any outstanding instruction, whether held or dispatched.
- R4: `in_ready` is 0 while `in_dst` equals either source of a held, not yet dispatched, instruction. Once that instruction dispatches, this condition no longer blocks entry.
- R5: A held instruction does not dispatch while either of its sources equals the destination of another outstanding instruction. It becomes eligible in the cycle after the writeback of that register. Its own destination never blocks it.
- R6: Among eligible instructions, the one that entered the window earliest is dispatched.
- R7: An instruction whose class bit in `fu_busy` is 1 does not dispatch. A younger eligible instruction for an idle class may dispatch in its place.
- R8: At most one instruction dispatches per cycle, and a dispatched instruction is never dispatched again.
- R9: A writeback whose `wb_dst` matches a dispatched instruction frees that slot for the next cycle. A writeback that matches no dispatched instruction has no effect.
- R10: `disp_op`, `disp_fu`, `disp_dst`, `disp_src1` and `disp_src2` carry the fields the chosen instruction had when it entered.
- R11: An instruction taken at a clock edge can dispatch no earlier than the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decode offers an instruction |
| in_ready | output | 1 | Window takes the offered instruction at this edge |
| in_op | input | OP_W | Opcode of the offered instruction |
| in_fu | input | FU_W | Functional-unit class of the offered instruction |
| in_dst | input | REG_W | Destination register |
| in_src1 | input | REG_W | First source register |
| in_src2 | input | REG_W | Second source register |
| fu_busy | input | 2**FU_W | One busy bit per functional-unit class |
| disp_valid | output | 1 | An instruction dispatches this cycle |
| disp_op | output | OP_W | Opcode of the dispatched instruction |
| disp_fu | output | FU_W | Class of the dispatched instruction |
| disp_dst | output | REG_W | Destination of the dispatched instruction |
| disp_src1 | output | REG_W | First source of the dispatched instruction |
| disp_src2 | output | REG_W | Second source of the dispatched instruction |
| wb_valid | input | 1 | Writeback broadcast this cycle |
| wb_dst | input | REG_W | Register written back |

## Verification
The assertions assume that writebacks only name registers whose producer was dispatched earlier. They also assume that `fu_busy` is a plain level, so a unit can be marked busy or idle in any cycle. The single-retire property depends on the window's own hazard rule: it holds only if no two outstanding instructions share a destination. The stimulus meets these assumptions because the bench draws each writeback from its own list of dispatched instructions. The one exception is a deliberate writeback to a register that has no dispatched producer, which the design must ignore. Register numbers in the sweep come from a narrow range, so conflicts of all three kinds occur often.

// File: rtl/iw_pkg.sv
package iw_pkg;
  localparam int unsigned IW_DEPTH_DEF = 8;
  localparam int unsigned IW_REG_W_DEF = 5;
  localparam int unsigned IW_FU_W_DEF  = 2;
  localparam int unsigned IW_OP_W_DEF  = 6;

  // lifecycle of one window slot
  typedef enum logic [1:0] {
    SLOT_FREE   = 2'd0,
    SLOT_HELD   = 2'd1,
    SLOT_ISSUED = 2'd2
  } slot_st_t;
endpackage

// File: rtl/iw_hazard.sv
// Entry check for a new instruction: WAW against every outstanding slot,
// WAR against the sources of slots that have not read operands yet.
module iw_hazard #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned REG_W = 5
) (
  input  logic [DEPTH-1:0]            out_vec,
  input  logic [DEPTH-1:0]            held_vec,
  input  logic [DEPTH-1:0][REG_W-1:0] dst_q,
  input  logic [DEPTH-1:0][REG_W-1:0] src1_q,
  input  logic [DEPTH-1:0][REG_W-1:0] src2_q,
  input  logic [REG_W-1:0]            in_dst,
  output logic                        waw_hit,
  output logic                        war_hit
);
  logic [DEPTH-1:0] waw_vec, war_vec;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign waw_vec[i] = out_vec[i] && (dst_q[i] == in_dst);
    assign war_vec[i] = held_vec[i] &&
                        ((src1_q[i] == in_dst) || (src2_q[i] == in_dst));
  end

  assign waw_hit = |waw_vec;
  assign war_hit = |war_vec;
endmodule

// File: rtl/iw_ready.sv
// Eligibility of each held slot: no outstanding producer for its sources
// (other than itself) and an idle target unit.
module iw_ready #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned REG_W = 5,
  parameter int unsigned FU_W  = 2
) (
  input  logic [DEPTH-1:0]            out_vec,
  input  logic [DEPTH-1:0]            held_vec,
  input  logic [DEPTH-1:0][REG_W-1:0] dst_q,
  input  logic [DEPTH-1:0][REG_W-1:0] src1_q,
  input  logic [DEPTH-1:0][REG_W-1:0] src2_q,
  input  logic [DEPTH-1:0][FU_W-1:0]  fu_q,
  input  logic [(1<<FU_W)-1:0]        fu_busy,
  output logic [DEPTH-1:0]            elig
);
  function automatic logic feeds(input logic [REG_W-1:0] prod,
                                 input logic [REG_W-1:0] a,
                                 input logic [REG_W-1:0] b);
    return (prod == a) || (prod == b);
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [DEPTH-1:0] raw_vec;
    for (genvar j = 0; j < DEPTH; j++) begin : g_prod
      if (i == j) begin : g_self
        assign raw_vec[j] = 1'b0;
      end else begin : g_other
        assign raw_vec[j] = out_vec[j] && feeds(dst_q[j], src1_q[i], src2_q[i]);
      end
    end
    assign elig[i] = held_vec[i] && !(|raw_vec) && !fu_busy[fu_q[i]];
  end
endmodule

// File: rtl/iw_age.sv
// Age matrix: older_q[i][j] set means slot i entered before slot j.
// Picks the oldest eligible slot as a one-hot grant.
module iw_age #(
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] alloc_oh,
  input  logic [DEPTH-1:0] elig,
  output logic [DEPTH-1:0] grant
);
  logic [DEPTH-1:0][DEPTH-1:0] older_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      older_q <= '0;
    end else begin
      for (int k = 0; k < DEPTH; k++) begin
        if (alloc_oh[k]) begin
          for (int i = 0; i < DEPTH; i++) begin
            older_q[k][i] <= 1'b0;
            older_q[i][k] <= (i != k);
          end
        end
      end
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_pick
    logic [DEPTH-1:0] beaten;
    for (genvar j = 0; j < DEPTH; j++) begin : g_rival
      assign beaten[j] = elig[j] && older_q[j][i];
    end
    assign grant[i] = elig[i] && !(|beaten);
  end
endmodule

// File: rtl/iw_window.sv
module iw_window
  import iw_pkg::*;
#(
  parameter int unsigned DEPTH = IW_DEPTH_DEF,
  parameter int unsigned REG_W = IW_REG_W_DEF,
  parameter int unsigned FU_W  = IW_FU_W_DEF,
  parameter int unsigned OP_W  = IW_OP_W_DEF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [OP_W-1:0]       in_op,
  input  logic [FU_W-1:0]       in_fu,
  input  logic [REG_W-1:0]      in_dst,
  input  logic [REG_W-1:0]      in_src1,
  input  logic [REG_W-1:0]      in_src2,
  input  logic [(1<<FU_W)-1:0]  fu_busy,
  output logic                  disp_valid,
  output logic [OP_W-1:0]       disp_op,
  output logic [FU_W-1:0]       disp_fu,
  output logic [REG_W-1:0]      disp_dst,
  output logic [REG_W-1:0]      disp_src1,
  output logic [REG_W-1:0]      disp_src2,
  input  logic                  wb_valid,
  input  logic [REG_W-1:0]      wb_dst
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  function automatic logic [DEPTH-1:0] lowest_one(input logic [DEPTH-1:0] v);
    return v & (~v + DEPTH'(1));
  endfunction

  function automatic logic [CNT_W-1:0] count_ones(input logic [DEPTH-1:0] v);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < DEPTH; i++) n = n + CNT_W'(v[i]);
    return n;
  endfunction

  slot_st_t [DEPTH-1:0]            st_q;
  logic     [DEPTH-1:0][OP_W-1:0]  op_q;
  logic     [DEPTH-1:0][FU_W-1:0]  fu_q;
  logic     [DEPTH-1:0][REG_W-1:0] dst_q, src1_q, src2_q;

  logic [DEPTH-1:0] out_vec, held_vec, iss_vec, free_vec;
  logic [DEPTH-1:0] alloc_oh, elig, grant, retire_vec;
  logic             waw_hit, war_hit, full, accept;
  logic [CNT_W-1:0] occ_cnt;

  for (genvar i = 0; i < DEPTH; i++) begin : g_vec
    assign out_vec[i]    = (st_q[i] != SLOT_FREE);
    assign held_vec[i]   = (st_q[i] == SLOT_HELD);
    assign iss_vec[i]    = (st_q[i] == SLOT_ISSUED);
    assign retire_vec[i] = iss_vec[i] && wb_valid && (dst_q[i] == wb_dst);
  end
  assign free_vec = ~out_vec;
  assign occ_cnt  = count_ones(out_vec);

  iw_hazard #(.DEPTH(DEPTH), .REG_W(REG_W)) u_hazard (
    .out_vec (out_vec),
    .held_vec(held_vec),
    .dst_q   (dst_q),
    .src1_q  (src1_q),
    .src2_q  (src2_q),
    .in_dst  (in_dst),
    .waw_hit (waw_hit),
    .war_hit (war_hit)
  );

  assign full     = ~|free_vec;
  assign in_ready = !full && !waw_hit && !war_hit;
  assign accept   = in_valid && in_ready;
  assign alloc_oh = accept ? lowest_one(free_vec) : '0;

  iw_ready #(.DEPTH(DEPTH), .REG_W(REG_W), .FU_W(FU_W)) u_ready (
    .out_vec (out_vec),
    .held_vec(held_vec),
    .dst_q   (dst_q),
    .src1_q  (src1_q),
    .src2_q  (src2_q),
    .fu_q    (fu_q),
    .fu_busy (fu_busy),
    .elig    (elig)
  );

  iw_age #(.DEPTH(DEPTH)) u_age (
    .clk     (clk),
    .rst_n   (rst_n),
    .alloc_oh(alloc_oh),
    .elig    (elig),
    .grant   (grant)
  );

  assign disp_valid = |grant;

  always_comb begin
    disp_op   = '0;
    disp_fu   = '0;
    disp_dst  = '0;
    disp_src1 = '0;
    disp_src2 = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (grant[i]) begin
        disp_op   = op_q[i];
        disp_fu   = fu_q[i];
        disp_dst  = dst_q[i];
        disp_src1 = src1_q[i];
        disp_src2 = src2_q[i];
      end
    end
  end

  // slot lifecycle: alloc, grant and retire touch disjoint states
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) st_q[i] <= SLOT_FREE;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (alloc_oh[i])        st_q[i] <= SLOT_HELD;
        else if (grant[i])      st_q[i] <= SLOT_ISSUED;
        else if (retire_vec[i]) st_q[i] <= SLOT_FREE;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (alloc_oh[i]) begin
        op_q[i]   <= in_op;
        fu_q[i]   <= in_fu;
        dst_q[i]  <= in_dst;
        src1_q[i] <= in_src1;
        src2_q[i] <= in_src2;
      end
    end
  end
endmodule

// File: rtl/iw_window_chk.sv
module iw_window_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned FU_W  = 2,
  parameter int unsigned CNT_W = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_ready,
  input logic                 full,
  input logic                 accept,
  input logic                 disp_valid,
  input logic [FU_W-1:0]      disp_fu,
  input logic [(1<<FU_W)-1:0] fu_busy,
  input logic [DEPTH-1:0]     grant,
  input logic [DEPTH-1:0]     retire_vec,
  input logic [CNT_W-1:0]     occ_cnt
);
  logic [CNT_W-1:0] acc_w, ret_w;
  assign acc_w = CNT_W'(accept);
  assign ret_w = CNT_W'(|retire_vec);

  // R2: a full window refuses decode
  a_r2_full_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !in_ready);

  // R7: dispatch never targets a busy unit
  a_r7_unit_idle: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> !fu_busy[disp_fu]);

  // R8: one grant per cycle at most
  a_r8_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R3: unique destinations mean a writeback retires one slot at most
  a_r3_single_retire: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(retire_vec));

  // R9: occupancy moves only by entries taken and slots retired
  a_r9_occupancy: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> occ_cnt == $past(occ_cnt) + $past(acc_w) - $past(ret_w));
endmodule

bind iw_window iw_window_chk #(.DEPTH(DEPTH), .FU_W(FU_W), .CNT_W(CNT_W)) u_iw_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .full      (full),
  .accept    (accept),
  .disp_valid(disp_valid),
  .disp_fu   (disp_fu),
  .fu_busy   (fu_busy),
  .grant     (grant),
  .retire_vec(retire_vec),
  .occ_cnt   (occ_cnt)
);

// File: tb/test_iw_window.sv
module test_iw_window;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [5:0] in_op = '0;
  logic [1:0] in_fu = '0;
  logic [4:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic [3:0] fu_busy = '0;
  logic       disp_valid;
  logic [5:0] disp_op;
  logic [1:0] disp_fu;
  logic [4:0] disp_dst, disp_src1, disp_src2;
  logic       wb_valid = 1'b0;
  logic [4:0] wb_dst = '0;

  int total = 0;
  int bad = 0;

  // bench model: 0 free, 1 held, 2 dispatched
  int m_st[N], m_op[N], m_fu[N], m_dst[N], m_s1[N], m_s2[N], m_seq[N];
  int seq_ctr = 0;
  bit exp_rdy;
  int exp_pick;

  always #(CLK_PERIOD/2) clk = ~clk;

  iw_window i_iw_window (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_fu(in_fu), .in_dst(in_dst), .in_src1(in_src1),
    .in_src2(in_src2), .fu_busy(fu_busy), .disp_valid(disp_valid),
    .disp_op(disp_op), .disp_fu(disp_fu), .disp_dst(disp_dst),
    .disp_src1(disp_src1), .disp_src2(disp_src2), .wb_valid(wb_valid),
    .wb_dst(wb_dst)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int occupancy();
    int n = 0;
    for (int i = 0; i < N; i++) if (m_st[i] != 0) n++;
    return n;
  endfunction

  // model of entry acceptance; also names the rule that decides it
  function automatic bit model_ready(output string tag);
    bit waw = 0, war = 0;
    for (int i = 0; i < N; i++) begin
      if (m_st[i] != 0 && m_dst[i] == int'(in_dst)) waw = 1;
      if (m_st[i] == 1 && (m_s1[i] == int'(in_dst) || m_s2[i] == int'(in_dst))) war = 1;
    end
    if (occupancy() == N) tag = "R2";
    else if (waw) tag = "R3";
    else if (war) tag = "R4";
    else tag = "R1";
    return (occupancy() < N) && !waw && !war;
  endfunction

  function automatic int model_pick();
    int best = -1;
    for (int i = 0; i < N; i++) begin
      bit raw = 0;
      if (m_st[i] != 1) continue;
      for (int k = 0; k < N; k++)
        if (k != i && m_st[k] != 0 && (m_dst[k] == m_s1[i] || m_dst[k] == m_s2[i])) raw = 1;
      if (raw || fu_busy[m_fu[i]]) continue;
      if (best < 0 || m_seq[i] < m_seq[best]) best = i;
    end
    return best;
  endfunction

  task automatic drive(input bit v, input int op, input int fu, input int d,
                       input int s1, input int s2, input logic [3:0] busy,
                       input bit wv, input int wd);
    in_valid = v; in_op = 6'(op); in_fu = 2'(fu); in_dst = 5'(d);
    in_src1 = 5'(s1); in_src2 = 5'(s2); fu_busy = busy;
    wb_valid = wv; wb_dst = 5'(wd);
    #1;
  endtask

  // compare against the model, clock once, then update the model
  task automatic advance();
    string tag;
    exp_rdy  = model_ready(tag);
    exp_pick = model_pick();
    check(in_ready == exp_rdy, tag, "in_ready", int'(in_ready), int'(exp_rdy));
    check(disp_valid == (exp_pick >= 0), "R6", "disp_valid", int'(disp_valid), int'(exp_pick >= 0));
    if (disp_valid && exp_pick >= 0)
      check({disp_op, disp_fu, disp_dst, disp_src1, disp_src2} ==
            {6'(m_op[exp_pick]), 2'(m_fu[exp_pick]), 5'(m_dst[exp_pick]),
             5'(m_s1[exp_pick]), 5'(m_s2[exp_pick])},
            "R10", "disp_dst", int'(disp_dst), m_dst[exp_pick]);
    @(posedge clk);
    if (wb_valid)
      for (int i = 0; i < N; i++)
        if (m_st[i] == 2 && m_dst[i] == int'(wb_dst)) m_st[i] = 0;
    if (exp_pick >= 0) m_st[exp_pick] = 2;
    if (in_valid && exp_rdy) begin
      for (int i = 0; i < N; i++) begin
        if (m_st[i] == 0) begin
          m_st[i] = 1; m_op[i] = int'(in_op); m_fu[i] = int'(in_fu);
          m_dst[i] = int'(in_dst); m_s1[i] = int'(in_src1); m_s2[i] = int'(in_src2);
          m_seq[i] = seq_ctr++;
          break;
        end
      end
    end
    #2;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL R8 watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) m_st[i] = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1: empty after reset
    drive(1, 0, 0, 1, 2, 3, 4'hF, 0, 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    check(disp_valid == 1'b0, "R1", "disp_valid after reset", int'(disp_valid), 0);
    in_valid = 1'b0; #1;
    advance();

    // fill all slots with every unit busy
    for (int k = 1; k <= 8; k++) begin
      drive(1, k, k % 4, k, 20, 21, 4'hF, 0, 0);
      advance();
    end
    drive(1, 9, 1, 9, 20, 21, 4'hF, 0, 0);
    check(in_ready == 1'b0, "R2", "in_ready when full", int'(in_ready), 0);
    check(disp_valid == 1'b0, "R7", "dispatch with all units busy", int'(disp_valid), 0);
    advance();

    // release units: oldest first, one per cycle
    for (int k = 1; k <= 8; k++) begin
      drive(1, 9, 1, 9, 20, 21, 4'h0, 0, 0);
      check(disp_valid && disp_dst == 5'(k), k == 1 ? "R6" : "R8", "dispatch order",
            int'(disp_dst), k);
      check(in_ready == 1'b0, "R2", "in_ready while held retried", int'(in_ready), 0);
      advance();
    end
    drive(1, 9, 1, 9, 20, 21, 4'h0, 0, 0);
    check(disp_valid == 1'b0, "R8", "no second dispatch", int'(disp_valid), 0);
    check(in_ready == 1'b0, "R2", "in-flight slots still occupied", int'(in_ready), 0);
    advance();

    drive(1, 9, 1, 9, 20, 21, 4'h0, 1, 3);
    advance();
    drive(1, 9, 1, 9, 20, 21, 4'h0, 0, 0);
    check(in_ready == 1'b1, "R9", "slot freed by writeback", int'(in_ready), 1);
    check(disp_valid == 1'b0, "R11", "no dispatch in entry cycle", int'(disp_valid), 0);
    advance();
    drive(0, 0, 0, 0, 0, 0, 4'h0, 0, 0);
    check(disp_valid && disp_dst == 5'd9, "R11", "dispatch one cycle later", int'(disp_dst), 9);
    advance();

    drive(0, 0, 0, 0, 0, 0, 4'h0, 1, 1); advance();
    drive(0, 0, 0, 0, 0, 0, 4'h0, 1, 2); advance();
    drive(0, 0, 0, 0, 0, 0, 4'h0, 1, 4); advance();

    // WAW against a dispatched instruction
    drive(1, 5, 0, 5, 30, 31, 4'h1, 0, 0);
    check(in_ready == 1'b0, "R3", "WAW with in-flight dst", int'(in_ready), 0);
    advance();
    drive(1, 5, 0, 5, 30, 31, 4'h1, 1, 5); advance();
    drive(1, 5, 0, 5, 30, 31, 4'h1, 0, 0);
    check(in_ready == 1'b1, "R3", "accepted after retire", int'(in_ready), 1);
    advance();

    // WAR against a held instruction
    drive(1, 7, 2, 30, 0, 0, 4'h1, 0, 0);
    check(in_ready == 1'b0, "R4", "WAR with held source", int'(in_ready), 0);
    check(disp_valid == 1'b0, "R7", "busy unit holds entry", int'(disp_valid), 0);
    advance();
    drive(1, 7, 2, 30, 0, 0, 4'h0, 0, 0);
    check(disp_valid && disp_dst == 5'd5, "R7", "dispatch once unit idle", int'(disp_dst), 5);
    advance();
    drive(1, 7, 2, 30, 0, 0, 4'h0, 0, 0);
    check(in_ready == 1'b1, "R4", "WAR cleared by dispatch", int'(in_ready), 1);
    advance();

    // RAW wait and wake-up
    drive(1, 8, 3, 12, 30, 1, 4'h0, 0, 0);
    check(disp_valid && disp_dst == 5'd30, "R6", "producer dispatch", int'(disp_dst), 30);
    advance();
    drive(0, 0, 0, 0, 0, 0, 4'h0, 0, 0);
    check(disp_valid == 1'b0, "R5", "consumer waits on producer", int'(disp_valid), 0);
    advance();
    drive(0, 0, 0, 0, 0, 0, 4'h0, 1, 12);
    advance();
    drive(1, 8, 3, 12, 1, 1, 4'h0, 0, 0);
    check(in_ready == 1'b0, "R9", "writeback to held entry ignored", int'(in_ready), 0);
    advance();
    drive(0, 0, 0, 0, 0, 0, 4'h0, 1, 30);
    check(disp_valid == 1'b0, "R5", "still waiting before writeback edge", int'(disp_valid), 0);
    advance();
    drive(0, 0, 0, 0, 0, 0, 4'h0, 0, 0);
    check(disp_valid && disp_dst == 5'd12, "R5", "woken consumer dispatches", int'(disp_dst), 12);
    advance();

    // sweep over a narrow register range
    for (int c = 0; c < 6000; c++) begin
      int cand[$];
      bit wv = 0;
      int wd = 0;
      for (int i = 0; i < N; i++) if (m_st[i] == 2) cand.push_back(m_dst[i]);
      if (cand.size() > 0 && $urandom_range(0, 2) != 0) begin
        wv = 1; wd = cand[$urandom_range(0, cand.size() - 1)];
      end else if ($urandom_range(0, 6) == 0) begin
        wv = 1; wd = $urandom_range(0, 7);
      end
      drive($urandom_range(0, 1), $urandom_range(0, 63), $urandom_range(0, 3),
            $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7),
            4'($urandom_range(0, 15) & $urandom_range(0, 15)), wv, wd);
      advance();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule